// File: doc/BRIEF.md
# Dual-Channel Two-Rank Angle Register

This block receives one 16-bit binary angle bus and keeps two separate angle words from it, one per channel. Each channel has two register ranks. The first rank is split into an upper byte and a lower byte, and each byte has its own enable. The second rank is a 16-bit holding word that takes both first-rank bytes at once when its load enable is high. The holding word is the channel's output and feeds the downstream sine/cosine generator. A host can therefore write the two bytes of a new angle one at a time over a shared bus and then switch the output to the new angle in a single step. When a channel's three enables are all tied high, the bus flows through to that channel's output.

The registers are clocked models of level-sensitive latches. A register updates on every rising clock edge at which its enable is high, and it keeps its value while the enable is low. Each enable has its own timing monitor. The monitor turns the minimum pulse width, setup time and hold time, given in nanoseconds, into clock-cycle counts using a parameterised clock period. It is a small state machine with three states:
- SHUT: the enable was low at the last sample. SHUT moves to OPEN when the enable is sampled high.
- OPEN: the enable is high and the monitor counts the pulse length. OPEN moves to GUARD on the sample where the enable falls. It moves straight to SHUT instead when the hold window is a single cycle.
- GUARD: the hold window after a falling enable. GUARD moves back to OPEN if the enable rises again. It moves to SHUT when the hold window runs out.

Any violation sets a sticky flag for its channel.

Top module: `dual_angle_latch`

## Requirements
- R1: An active-low asynchronous reset clears both first-rank bytes, the holding word and the violation flag of every channel to zero.
- R2: At each rising edge where a channel's upper-byte enable is high, its upper first-rank byte captures data_i[15:8]. data_i[15] is the most significant angle bit and weighs 180 degrees. While that enable is low, the byte keeps its value.
- R3: At each rising edge where a channel's lower-byte enable is high, its lower first-rank byte captures data_i[7:0]. data_i[0] is the least significant bit, about 0.0055 degrees. While that enable is low, the byte keeps its value.
- R4: At each rising edge where a channel's load enable is high, the holding word takes {upper byte, lower byte} as they stood before that edge. angle_o shows the holding word, and it does not change while the load enable is low.
- R5: While all three enables of a channel stay high, angle_o equals the bus value that was sampled two rising edges earlier.
- R6: The enables of one channel have no effect on the registers or the flag of the other channel.
- R7: The channel's flag is set if an enable is sampled low after fewer than ceil(PULSE_NS/CLK_NS) consecutive high samples.
- R8: The channel's flag is set if an enable falls when the data that enable guards has not stayed constant for at least ceil(SETUP_NS/CLK_NS) samples before the falling sample. The guarded data is the bus byte for a byte enable and the first-rank word for the load enable.
- R9: The flag is set if the guarded data changes on any of the ceil(HOLD_NS/CLK_NS) samples that start at the falling sample. The window closes early if the enable is sampled high again.
- R10: Each channel has its own violation flag. Once set, the flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_i | input | AW | Shared angle bus |
| en_hi_i | input | NCH | Upper-byte enable, one per channel |
| en_lo_i | input | NCH | Lower-byte enable, one per channel |
| en_load_i | input | NCH | Holding-word load enable, one per channel |
| angle_o | output | NCH x AW | Held angle of each channel |
| viol_o | output | NCH | Sticky timing-violation flag of each channel |

## Verification
The hardest cases to reach are the hold-window boundaries. One is a bus change that lands on the first sample after the window and must leave the flag clear. The other is a change that arrives after the enable has risen again, which closes the window early. The stimulus reaches both by counting falling clock edges from the enable's drop before it moves the bus. Every other timing case is first set up under clean conditions, so that only one of width, setup or hold is broken in it. A behavioural model of the ranks and the monitors is checked against the outputs on every cycle.

// File: rtl/angle_latch_pkg.sv
package angle_latch_pkg;

    // Window monitor states
    typedef enum logic [1:0] {
        S_SHUT  = 2'd0,
        S_OPEN  = 2'd1,
        S_GUARD = 2'd2
    } win_state_e;

    // Round a time in ns up to whole clock periods
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

endpackage

// File: rtl/clk_latch.sv
module clk_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Clocked model of a level-sensitive latch: follows d while en is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

    // R2 / R3 / R4: an enabled edge captures the sampled input
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (q == $past(d)));

endmodule

// File: rtl/latch_timing_chk.sv
module latch_timing_chk
    import angle_latch_pkg::*;
#(
    parameter int DW        = 8,
    parameter int WIDTH_CYC = 20,
    parameter int SETUP_CYC = 10,
    parameter int HOLD_CYC  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] d,
    output logic          viol
);

    localparam int RW = $clog2(WIDTH_CYC + 1);
    localparam int SW = $clog2(SETUP_CYC + 1);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [RW-1:0] RUN_MIN  = RW'(WIDTH_CYC);
    localparam logic [SW-1:0] STAB_MIN = SW'(SETUP_CYC);
    localparam logic [HW-1:0] GUARD_LD = HW'(HOLD_CYC - 1);
    localparam bit            HAS_GUARD = (HOLD_CYC > 1);

    win_state_e    state_q, state_d;
    logic [RW-1:0] run_q;
    logic [SW-1:0] stab_q;
    logic [HW-1:0] gcnt_q;
    logic [DW-1:0] d_prev;
    logic          chg;
    logic          fall;

    assign chg  = (d != d_prev);
    assign fall = (state_q == S_OPEN) && !en;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_SHUT;
        end else begin
            state_q <= state_d;
        end
    end

    // Pulse length, data stability and hold window counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            stab_q <= '0;
            gcnt_q <= '0;
            d_prev <= '0;
        end else begin
            d_prev <= d;
            if (!en) begin
                run_q <= '0;
            end else if (run_q != RUN_MIN) begin
                run_q <= run_q + 1'b1;
            end
            if (chg) begin
                stab_q <= '0;
            end else if (stab_q != STAB_MIN) begin
                stab_q <= stab_q + 1'b1;
            end
            if (fall) begin
                gcnt_q <= GUARD_LD;
            end else if ((state_q == S_GUARD) && !en) begin
                gcnt_q <= gcnt_q - 1'b1;
            end
        end
    end

    // Next state and violation output
    always_comb begin
        state_d = state_q;
        viol    = 1'b0;
        unique case (state_q)
            S_SHUT: begin
                if (en) state_d = S_OPEN;
            end
            S_OPEN: begin
                if (!en) begin
                    viol    = (run_q < RUN_MIN) || (stab_q < STAB_MIN) || chg;
                    state_d = HAS_GUARD ? S_GUARD : S_SHUT;
                end
            end
            S_GUARD: begin
                if (en) begin
                    state_d = S_OPEN;
                end else begin
                    viol = chg;
                    if (gcnt_q == HW'(1)) state_d = S_SHUT;
                end
            end
            default: state_d = S_SHUT;
        endcase
    end

    // R9: the hold window never sits at an exhausted count
    a_r9_guard_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GUARD) |-> (gcnt_q != '0));

    // R7: a pulse that is still open keeps counting its length
    a_r7_run_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && ($past(run_q) != RUN_MIN)) |-> (run_q == $past(run_q) + 1'b1));

endmodule

// File: rtl/angle_channel.sv
module angle_channel #(
    parameter int AW        = 16,
    parameter int WIDTH_CYC = 20,
    parameter int SETUP_CYC = 10,
    parameter int HOLD_CYC  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] data_i,
    input  logic          en_hi_i,
    input  logic          en_lo_i,
    input  logic          en_load_i,
    output logic [AW-1:0] angle_o,
    output logic          viol_o
);

    localparam int LB = AW / 2;
    localparam int UB = AW - LB;

    logic [UB-1:0] hi_q;
    logic [LB-1:0] lo_q;
    logic [2:0]    flag;

    clk_latch #(.W(UB)) u_hi (
        .clk(clk), .rst_n(rst_n), .en(en_hi_i), .d(data_i[AW-1:LB]), .q(hi_q)
    );
    clk_latch #(.W(LB)) u_lo (
        .clk(clk), .rst_n(rst_n), .en(en_lo_i), .d(data_i[LB-1:0]), .q(lo_q)
    );
    clk_latch #(.W(AW)) u_hold (
        .clk(clk), .rst_n(rst_n), .en(en_load_i), .d({hi_q, lo_q}), .q(angle_o)
    );

    latch_timing_chk #(.DW(UB), .WIDTH_CYC(WIDTH_CYC), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) u_chk_hi (
        .clk(clk), .rst_n(rst_n), .en(en_hi_i), .d(data_i[AW-1:LB]), .viol(flag[0])
    );
    latch_timing_chk #(.DW(LB), .WIDTH_CYC(WIDTH_CYC), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) u_chk_lo (
        .clk(clk), .rst_n(rst_n), .en(en_lo_i), .d(data_i[LB-1:0]), .viol(flag[1])
    );
    latch_timing_chk #(.DW(AW), .WIDTH_CYC(WIDTH_CYC), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) u_chk_ld (
        .clk(clk), .rst_n(rst_n), .en(en_load_i), .d({hi_q, lo_q}), .viol(flag[2])
    );

    // Sticky violation flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_o <= 1'b0;
        end else if (|flag) begin
            viol_o <= 1'b1;
        end
    end

    a_r10_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag) |=> viol_o);

    a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |=> viol_o);

endmodule

// File: rtl/dual_angle_latch.sv
module dual_angle_latch
    import angle_latch_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int AW       = 16,
    parameter int CLK_NS   = 10,
    parameter int PULSE_NS = 200,
    parameter int SETUP_NS = 100,
    parameter int HOLD_NS  = 50
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           data_i,
    input  logic [NCH-1:0]          en_hi_i,
    input  logic [NCH-1:0]          en_lo_i,
    input  logic [NCH-1:0]          en_load_i,
    output logic [NCH-1:0][AW-1:0]  angle_o,
    output logic [NCH-1:0]          viol_o
);

    localparam int WIDTH_CYC = ns_to_cyc(PULSE_NS, CLK_NS);
    localparam int SETUP_CYC = ns_to_cyc(SETUP_NS, CLK_NS);
    localparam int HOLD_CYC  = ns_to_cyc(HOLD_NS, CLK_NS);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        angle_channel #(
            .AW(AW), .WIDTH_CYC(WIDTH_CYC), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)
        ) u_ch (
            .clk(clk), .rst_n(rst_n), .data_i(data_i),
            .en_hi_i(en_hi_i[c]), .en_lo_i(en_lo_i[c]), .en_load_i(en_load_i[c]),
            .angle_o(angle_o[c]), .viol_o(viol_o[c])
        );

        // R4 / R6: without its own load, a channel's output stays put
        a_r6_out_steady: assert property (@(posedge clk) disable iff (!rst_n)
            !en_load_i[c] |=> $stable(angle_o[c]));
    end

endmodule

// File: tb/tb_dual_angle_latch.sv
module tb_dual_angle_latch;

    localparam int TCLK = 10;
    localparam int PW   = (200 + TCLK - 1) / TCLK;
    localparam int SU   = (100 + TCLK - 1) / TCLK;
    localparam int HO   = (50 + TCLK - 1) / TCLK;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [15:0]      data = '0;
    logic [1:0]       en_hi = '0, en_lo = '0, en_ld = '0;
    logic [1:0][15:0] angle;
    logic [1:0]       viol;

    dual_angle_latch #(.CLK_NS(TCLK)) dut (
        .clk(clk), .rst_n(rst_n), .data_i(data),
        .en_hi_i(en_hi), .en_lo_i(en_lo), .en_load_i(en_ld),
        .angle_o(angle), .viol_o(viol)
    );

    always #(TCLK/2) clk = ~clk;

    int    n_chk = 0, n_err = 0;
    string cur_req = "R1";

    // Behavioural reference
    int m_hi[2], m_lo[2], m_hold[2];
    bit m_viol[2];
    int c_pen[6], c_run[6], c_stab[6], c_dprev[6], c_guard[6];

    function automatic bit mstep(int k, bit en, int d);
        bit v;
        bit chg;
        v   = 1'b0;
        chg = (d != c_dprev[k]);
        if (c_pen[k] != 0 && !en) begin
            v = (c_run[k] < PW) || (c_stab[k] < SU) || chg;
            c_guard[k] = HO - 1;
        end else if (!en && c_guard[k] > 0) begin
            if (chg) v = 1'b1;
            c_guard[k] = c_guard[k] - 1;
        end
        if (en) c_guard[k] = 0;
        c_run[k]   = en ? ((c_run[k] < PW) ? c_run[k] + 1 : PW) : 0;
        c_stab[k]  = chg ? 0 : ((c_stab[k] < SU) ? c_stab[k] + 1 : SU);
        c_dprev[k] = d;
        c_pen[k]   = en;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_hi[c] = 0; m_lo[c] = 0; m_hold[c] = 0; m_viol[c] = 0;
            end
            for (int k = 0; k < 6; k++) begin
                c_pen[k] = 0; c_run[k] = 0; c_stab[k] = 0; c_dprev[k] = 0; c_guard[k] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                int  old_word;
                bit  v0, v1, v2;
                old_word = m_hi[c] * 256 + m_lo[c];
                v0 = mstep(c*3+0, en_hi[c], int'(data[15:8]));
                v1 = mstep(c*3+1, en_lo[c], int'(data[7:0]));
                v2 = mstep(c*3+2, en_ld[c], old_word);
                if (en_ld[c]) m_hold[c] = old_word;
                if (en_hi[c]) m_hi[c] = int'(data[15:8]);
                if (en_lo[c]) m_lo[c] = int'(data[7:0]);
                if (v0 || v1 || v2) m_viol[c] = 1'b1;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the clock edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            for (int c = 0; c < 2; c++) begin
                chk({cur_req, " angle"}, int'(angle[c]), m_hold[c]);
                chk({cur_req, " flag"}, int'(viol[c]), int'(m_viol[c]));
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_en(int ch, int sel, bit v);
        case (sel)
            0: en_hi[ch] = v;
            1: en_lo[ch] = v;
            default: en_ld[ch] = v;
        endcase
    endtask

    task automatic pulse(int ch, int sel, logic [15:0] val, int pre, int len, int post);
        data = val;
        tick(pre);
        set_en(ch, sel, 1'b1);
        tick(len);
        set_en(ch, sel, 1'b0);
        tick(post);
    endtask

    task automatic do_reset();
        en_hi = '0; en_lo = '0; en_ld = '0;
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        tick(3);
        // R1: reset state
        chk("R1 angle0", int'(angle[0]), 0);
        chk("R1 angle1", int'(angle[1]), 0);
        chk("R1 flags", int'(viol), 0);
        rst_n = 1'b1;
        tick(1);

        // R5: all enables high, bus changes every cycle
        cur_req = "R5";
        en_hi = '1; en_lo = '1; en_ld = '1;
        for (int i = 0; i < 25; i++) begin
            data = 16'((i * 16'h1357) ^ 16'h0F0F);
            tick(1);
        end
        data = 16'hBEEF;
        tick(2);
        chk("R5 pass-through ch0", int'(angle[0]), 16'hBEEF);
        chk("R5 pass-through ch1", int'(angle[1]), 16'hBEEF);
        do_reset();

        // R2, R3, R4, R6: clean byte writes and loads
        cur_req = "R2";
        pulse(0, 0, 16'hC377, 0, 22, 6);
        cur_req = "R3";
        pulse(0, 1, 16'h1181, 0, 22, 6);
        chk("R4 no load yet", int'(angle[0]), 0);
        cur_req = "R4";
        pulse(0, 2, 16'h0000, 0, 22, 6);
        chk("R4 load ch0 (R2 upper byte held)", int'(angle[0]), 16'hC381);
        chk("R6 ch1 untouched", int'(angle[1]), 0);
        chk("R7 no false flag", int'(viol), 0);
        cur_req = "R6";
        pulse(1, 0, 16'h5A00, 0, 22, 6);
        pulse(1, 1, 16'h00A5, 0, 22, 6);
        pulse(1, 2, 16'h0000, 0, 22, 6);
        chk("R6 ch0 keeps", int'(angle[0]), 16'hC381);
        chk("R4 load ch1", int'(angle[1]), 16'h5AA5);
        chk("R6 flags clear", int'(viol), 0);
        do_reset();

        // R7: short pulse on channel 1
        cur_req = "R7";
        pulse(1, 0, 16'h4400, 12, 5, 8);
        chk("R7 short pulse ch1", int'(viol[1]), 1);
        chk("R7 ch0 clean", int'(viol[0]), 0);
        tick(10);
        chk("R10 sticky", int'(viol[1]), 1);
        do_reset();
        chk("R10 cleared by reset", int'(viol), 0);

        // R8: bus changes five samples before the fall
        cur_req = "R8";
        data = 16'h0033;
        en_lo[0] = 1'b1;
        tick(20);
        data = 16'h0034;
        tick(5);
        en_lo[0] = 1'b0;
        tick(8);
        chk("R8 setup ch0", int'(viol[0]), 1);
        chk("R8 ch1 clean", int'(viol[1]), 0);
        do_reset();

        // R9: change inside the hold window
        cur_req = "R9";
        data = 16'h7000;
        en_hi[0] = 1'b1;
        tick(22);
        en_hi[0] = 1'b0;
        tick(2);
        data = 16'h7100;
        tick(6);
        chk("R9 hold inside window", int'(viol[0]), 1);
        do_reset();

        // R9: change on the first sample after the window
        data = 16'h2200;
        en_hi[0] = 1'b1;
        tick(22);
        en_hi[0] = 1'b0;
        tick(HO);
        data = 16'h2300;
        tick(6);
        chk("R9 edge of window", int'(viol[0]), 0);

        // R9: window closes when the enable returns
        data = 16'h4400;
        tick(12);
        en_hi[0] = 1'b1;
        tick(22);
        en_hi[0] = 1'b0;
        tick(2);
        en_hi[0] = 1'b1;
        data = 16'h4500;
        tick(22);
        en_hi[0] = 1'b0;
        tick(8);
        chk("R9 early close", int'(viol[0]), 0);

        finish_run();
    end

endmodule